// File: doc/BRIEF.md
# Bus Event Recognizer

This block watches one on-chip bus and decides, in the clock cycle a transfer is presented, whether that transfer meets any of a set of programmed conditions. Each comparator looks at the address, the data word and the transfer direction together. A transfer is a hit for a comparator only if three things hold at once: the address falls inside an inclusive window, the data bits selected by a mask equal a stored value, and the direction is one that the comparator accepts.

The comparator hits feed a short ordered sequencer. Each step of the sequencer names the comparator it is waiting for. When the hit for the last step arrives, the block raises a trigger. The trigger can be routed to a breakpoint request and to pulses that start or stop trace collection. A simple write-only register port sets every condition. The sequencer can be sent back to its first step from that port. Every output is registered, so each result appears one clock after the bus cycle that caused it.

Top module: `bus_event_recognizer`

## Requirements
- R1: A comparator hit needs `busValid` high, and the address, data and direction conditions must all hold in that same cycle; `cmpHit[k]` is high for exactly the one clock that follows such a cycle.
- R2: The address condition is `lo <= busAddr <= hi`, with both bounds inclusive; if `lo > hi`, the comparator never hits.
- R3: The data condition is `((busData ^ value) & mask) == 0`; a mask of zero makes the comparator ignore data.
- R4: Bits [1:0] of a comparator's type register select the accepted transfers: 0 accepts none, 1 accepts reads only (`busWrite`=0), 2 accepts writes only, and 3 accepts both.
- R5: The sequencer begins at step 0. Step s waits for the comparator held in its select register. It moves to the next step only on a hit of that comparator, and hits of any other comparator are ignored. A hit on the last step pulses `seqTrigger` for one clock, starting one clock after that bus cycle, and returns the sequencer to step 0.
- R6: A value L in bits [1:0] of the length register makes the sequence L+1 steps long. Writing that register sends the sequencer to step 0 and suppresses a trigger in the same cycle.
- R7: `bkptReq` pulses together with `seqTrigger` when bit 0 of the action register is set, and stays low otherwise.
- R8: `traceOn` pulses with `seqTrigger` when action bit 1 is set, and `traceOff` pulses with it when action bit 2 is set.
- R9: Any write to the sequence-restart address sends the sequencer to step 0 and suppresses a trigger in that same cycle. Comparator hits are not affected by it.
- R10: After reset, every output is low, all comparator type fields are 0 (so no comparator hits), every step selects comparator 0, the length is one step, and all action bits are 0.
- R11: Register addresses: comparator k, field f is at 8k+f, where f is 0 for low bound, 1 for high bound, 2 for data value, 3 for data mask and 4 for type. The select register for step s is at 0x20+s (bits [1:0]). Length is at 0x28, actions at 0x29, and sequence restart at 0x2A. A write applies to bus cycles from the next clock onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 6 | Register address |
| cfgWrData | input | DATA_W | Register write data |
| busValid | input | 1 | A bus transfer is present this cycle |
| busWrite | input | 1 | 1 = write transfer, 0 = read transfer |
| busAddr | input | ADDR_W | Transfer address |
| busData | input | DATA_W | Transfer data |
| cmpHit | output | NUM_CMP | Hit of each comparator, one clock late |
| seqTrigger | output | 1 | Sequence-complete pulse |
| bkptReq | output | 1 | Breakpoint request pulse |
| traceOn | output | 1 | Start-trace pulse |
| traceOff | output | 1 | Stop-trace pulse |

## Verification
A corrupted comparator register shows up on `cmpHit` in the clock after the first transfer that crosses the affected bound, mask bit or direction. The address, data and type sweeps are built to make that happen within a few cycles. A wrong sequencer step stays hidden until the selected comparator hits. After that it shows as a trigger that comes too early, too late or not at all, so the bench checks all five outputs on every bus cycle and runs long mixed streams. A sequencer that fails to restart shows on the next expected trigger after a restart or length write.

// File: rtl/ber_pkg.sv
package ber_pkg;

  typedef enum logic [2:0] {
    FLD_LO   = 3'd0,
    FLD_HI   = 3'd1,
    FLD_VAL  = 3'd2,
    FLD_MASK = 3'd3,
    FLD_TYPE = 3'd4
  } cmpField_e;

  typedef struct packed {
    logic      wrEn;
    logic [2:0] cmpIdx;
    cmpField_e field;
  } cfgStrobe_t;

  localparam int CFG_AW    = 6;
  localparam int SEQ_BASE  = 32;
  localparam int LEN_ADDR  = 40;
  localparam int ACT_ADDR  = 41;
  localparam int SRST_ADDR = 42;

endpackage

// File: rtl/ber_datapath.sv
module ber_datapath
  import ber_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int NUM_CMP = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfgStrobe_t         strobe,
  input  logic [DATA_W-1:0]  cfgWrData,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busData,
  output logic [NUM_CMP-1:0] hitNow,
  output logic [NUM_CMP-1:0] hitQ
);

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    logic [ADDR_W-1:0] loQ, hiQ;
    logic [DATA_W-1:0] valQ, maskQ;
    logic [1:0]        typeQ;
    logic              wrHere, typeOk, addrOk, dataOk;

    assign wrHere = strobe.wrEn && (strobe.cmpIdx == 3'(k));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        loQ   <= '0;
        hiQ   <= '0;
        valQ  <= '0;
        maskQ <= '0;
        typeQ <= '0;
      end else if (wrHere) begin
        case (strobe.field)
          FLD_LO:   loQ   <= cfgWrData[ADDR_W-1:0];
          FLD_HI:   hiQ   <= cfgWrData[ADDR_W-1:0];
          FLD_VAL:  valQ  <= cfgWrData;
          FLD_MASK: maskQ <= cfgWrData;
          FLD_TYPE: typeQ <= cfgWrData[1:0];
          default:  ;
        endcase
      end
    end

    always_comb begin
      typeOk = busWrite ? typeQ[1] : typeQ[0];
      addrOk = (busAddr >= loQ) && (busAddr <= hiQ);
      dataOk = ((busData ^ valQ) & maskQ) == '0;
    end

    assign hitNow[k] = busValid && typeOk && addrOk && dataOk;

    // R1: a registered hit only follows a valid transfer
    a_r1_hit_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
      hitQ[k] |-> $past(busValid));
    // R4: the direction of the transfer was accepted by the type field
    a_r4_type_gate: assert property (@(posedge clk) disable iff (!rstN)
      hitQ[k] |-> ($past(busWrite) ? $past(typeQ[1]) : $past(typeQ[0])));
    // R2: an inverted window never produces a hit
    a_r2_window_order: assert property (@(posedge clk) disable iff (!rstN)
      hitQ[k] |-> $past(loQ <= hiQ));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hitQ <= '0;
    else       hitQ <= hitNow;
  end

endmodule

// File: rtl/ber_control.sv
module ber_control
  import ber_pkg::*;
#(
  parameter int NUM_CMP   = 4,
  parameter int NUM_STEPS = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [CFG_AW-1:0]  cfgAddr,
  input  logic [2:0]         ctlData,
  input  logic [NUM_CMP-1:0] hitNow,
  output cfgStrobe_t         strobe,
  output logic               trigger,
  output logic               bkptReq,
  output logic               traceOn,
  output logic               traceOff
);

  localparam int SEL_W    = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1;
  localparam int STEP_W   = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1;
  localparam int CMP_SPAN = NUM_CMP * 8;

  logic [NUM_STEPS-1:0][SEL_W-1:0] stepSel;
  logic [STEP_W-1:0] stepIdx, seqLast;
  logic [2:0]        actQ;
  logic              lenWr, actWr, srstWr;
  logic [SEL_W-1:0]  curSel;
  logic              advance, lastStep, fire;

  always_comb begin
    strobe.wrEn   = cfgWrEn && (cfgAddr < CFG_AW'(CMP_SPAN)) && (cfgAddr[2:0] <= 3'd4);
    strobe.cmpIdx = cfgAddr[5:3];
    strobe.field  = (cfgAddr[2:0] <= 3'd4) ? cmpField_e'(cfgAddr[2:0]) : FLD_LO;
  end

  assign lenWr  = cfgWrEn && (cfgAddr == CFG_AW'(LEN_ADDR));
  assign actWr  = cfgWrEn && (cfgAddr == CFG_AW'(ACT_ADDR));
  assign srstWr = cfgWrEn && (cfgAddr == CFG_AW'(SRST_ADDR));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepSel <= '0;
      seqLast <= '0;
      actQ    <= '0;
    end else begin
      for (int s = 0; s < NUM_STEPS; s++)
        if (cfgWrEn && (cfgAddr == CFG_AW'(SEQ_BASE + s)))
          stepSel[s] <= ctlData[SEL_W-1:0];
      if (lenWr) seqLast <= ctlData[STEP_W-1:0];
      if (actWr) actQ <= ctlData;
    end
  end

  always_comb begin
    curSel   = stepSel[stepIdx];
    advance  = hitNow[curSel];
    lastStep = (stepIdx == seqLast);
    fire     = advance && lastStep && !srstWr && !lenWr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepIdx  <= '0;
      trigger  <= 1'b0;
      bkptReq  <= 1'b0;
      traceOn  <= 1'b0;
      traceOff <= 1'b0;
    end else begin
      if (srstWr || lenWr)  stepIdx <= '0;
      else if (advance)     stepIdx <= lastStep ? '0 : stepIdx + 1'b1;
      trigger  <= fire;
      bkptReq  <= fire && actQ[0];
      traceOn  <= fire && actQ[1];
      traceOff <= fire && actQ[2];
    end
  end

  // R5: the sequencer never runs past the programmed last step
  a_r5_step_bounded: assert property (@(posedge clk) disable iff (!rstN)
    stepIdx <= seqLast);
  // R5: a trigger pulse coincides with the sequencer back at step 0
  a_r5_fire_rewinds: assert property (@(posedge clk) disable iff (!rstN)
    trigger |-> (stepIdx == '0));
  // R7: breakpoint request only accompanies a trigger
  a_r7_bkpt_with_trig: assert property (@(posedge clk) disable iff (!rstN)
    bkptReq |-> trigger);
  // R8: trace pulses only accompany a trigger
  a_r8_trace_with_trig: assert property (@(posedge clk) disable iff (!rstN)
    (traceOn || traceOff) |-> trigger);
  // R9: a restart write clears the step and blocks the trigger
  a_r9_restart: assert property (@(posedge clk) disable iff (!rstN)
    srstWr |=> (stepIdx == '0) && !trigger);

endmodule

// File: rtl/bus_event_recognizer.sv
module bus_event_recognizer
  import ber_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int NUM_CMP   = 4,
  parameter int NUM_STEPS = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [5:0]         cfgAddr,
  input  logic [DATA_W-1:0]  cfgWrData,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busData,
  output logic [NUM_CMP-1:0] cmpHit,
  output logic               seqTrigger,
  output logic               bkptReq,
  output logic               traceOn,
  output logic               traceOff
);

  cfgStrobe_t         strobe;
  logic [NUM_CMP-1:0] hitNow;

  ber_control #(.NUM_CMP(NUM_CMP), .NUM_STEPS(NUM_STEPS)) u_ctl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .ctlData(cfgWrData[2:0]), .hitNow(hitNow), .strobe(strobe),
    .trigger(seqTrigger), .bkptReq(bkptReq), .traceOn(traceOn), .traceOff(traceOff)
  );

  ber_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CMP(NUM_CMP)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgWrData(cfgWrData),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr), .busData(busData),
    .hitNow(hitNow), .hitQ(cmpHit)
  );

endmodule

// File: tb/tb_bus_event_recognizer.sv
module tb_bus_event_recognizer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [5:0]  cfgAddr = '0;
  logic [15:0] cfgWrData = '0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [15:0] busAddr = '0, busData = '0;
  logic [3:0]  cmpHit;
  logic        seqTrigger, bkptReq, traceOn, traceOff;

  int nChecks = 0, nFails = 0;
  int lo[4], hi[4], val[4], msk[4], ct[4], sel[4];
  int lastStep = 0, act = 0, stepE = 0;

  always #2 clk = ~clk;

  bus_event_recognizer dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr), .busData(busData),
    .cmpHit(cmpHit), .seqTrigger(seqTrigger), .bkptReq(bkptReq),
    .traceOn(traceOn), .traceOff(traceOff)
  );

  task automatic check(string req, int act_v, int exp_v);
    nChecks++;
    if (act_v != exp_v) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  function automatic bit expHit(int k, bit v, bit w, int a, int d);
    bit typeOk = w ? ct[k][1] : ct[k][0];
    return v && typeOk && (a >= lo[k]) && (a <= hi[k]) && (((d ^ val[k]) & msk[k]) == 0);
  endfunction

  // R11: register write, model mirrors the map
  task automatic cfgWrite(int addr, int data);
    cfgWrEn = 1'b1; cfgAddr = 6'(addr); cfgWrData = 16'(data);
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (addr < 32) begin
      case (addr % 8)
        0: lo[addr/8]  = data & 16'hFFFF;
        1: hi[addr/8]  = data & 16'hFFFF;
        2: val[addr/8] = data & 16'hFFFF;
        3: msk[addr/8] = data & 16'hFFFF;
        4: ct[addr/8]  = data & 3;
        default: ;
      endcase
    end else if (addr >= 32 && addr < 36) sel[addr-32] = data & 3;
    else if (addr == 40) begin lastStep = data & 3; stepE = 0; end
    else if (addr == 41) act = data & 7;
    else if (addr == 42) stepE = 0;
  endtask

  // one bus cycle, optionally with a simultaneous restart write (R9)
  task automatic cyc(bit v, bit w, int a, int d, bit restart);
    bit [3:0] eh;
    bit fire = 0;
    for (int k = 0; k < 4; k++) eh[k] = expHit(k, v, w, a, d);
    if (restart) stepE = 0;
    else if (eh[sel[stepE]]) begin
      if (stepE == lastStep) begin fire = 1; stepE = 0; end
      else stepE++;
    end
    busValid = v; busWrite = w; busAddr = 16'(a); busData = 16'(d);
    if (restart) begin cfgWrEn = 1'b1; cfgAddr = 6'd42; end
    @(negedge clk);
    cfgWrEn = 1'b0; busValid = 1'b0;
    check("R1 cmpHit", int'(cmpHit), int'(eh));
    check("R5 seqTrigger", int'(seqTrigger), int'(fire));
    check("R7 bkptReq", int'(bkptReq), int'(fire && act[0]));
    check("R8 traceOn", int'(traceOn), int'(fire && act[1]));
    check("R8 traceOff", int'(traceOff), int'(fire && act[2]));
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #800000;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    for (int k = 0; k < 4; k++) begin lo[k]=0; hi[k]=0; val[k]=0; msk[k]=0; ct[k]=0; sel[k]=0; end
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 cmpHit", int'(cmpHit), 0);
    check("R10 seqTrigger", int'(seqTrigger), 0);
    check("R10 actions", int'({bkptReq, traceOn, traceOff}), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R10: type fields cleared, nothing hits
    for (int i = 0; i < 16; i++) cyc(1'b1, i[0], i * 37, i * 91, 1'b0);

    // R2: inclusive window sweep on comparator 0
    cfgWrite(0, 16'h0010); cfgWrite(1, 16'h0020); cfgWrite(4, 3);
    for (int a = 0; a < 48; a++) begin
      cyc(1'b1, 1'b0, a, a, 1'b0);
      cyc(1'b1, 1'b1, a, ~a, 1'b0);
    end
    cyc(1'b0, 1'b0, 16'h0015, 0, 1'b0); // R1: no valid, no hit

    // R3, R4: masked data compare on comparator 1, writes only
    cfgWrite(8, 0); cfgWrite(9, 16'hFFFF); cfgWrite(10, 16'h00A5);
    cfgWrite(11, 16'h00FF); cfgWrite(12, 2);
    for (int d = 0; d < 256; d++) begin
      cyc(1'b1, 1'b1, 16'h0100, (d * 16'h0101) ^ 16'h5A00, 1'b0);
      if (d[3:0] == 0) cyc(1'b1, 1'b0, 16'h0100, 16'h00A5, 1'b0);
    end
    cfgWrite(11, 0); // R3: mask zero ignores data
    for (int d = 0; d < 8; d++) cyc(1'b1, 1'b1, 16'h0200, d * 16'h1357, 1'b0);

    // R4: exhaustive type field on comparator 2
    cfgWrite(16, 16'h0040); cfgWrite(17, 16'h0040);
    for (int t = 0; t < 4; t++) begin
      cfgWrite(20, t);
      cyc(1'b1, 1'b0, 16'h0040, 0, 1'b0);
      cyc(1'b1, 1'b1, 16'h0040, 0, 1'b0);
      cyc(1'b1, 1'b1, 16'h0041, 0, 1'b0);
    end

    // R2: inverted window on comparator 3 never hits
    cfgWrite(24, 16'h0030); cfgWrite(25, 16'h0020); cfgWrite(28, 3);
    for (int a = 16'h18; a < 16'h38; a++) cyc(1'b1, a[0], a, 0, 1'b0);

    // R5, R6: three-step sequence cmp2 -> cmp0 -> cmp3
    cfgWrite(20, 3); cfgWrite(11, 16'hFFFF);
    cfgWrite(24, 16'h0050); cfgWrite(25, 16'h0050);
    cfgWrite(32, 2); cfgWrite(33, 0); cfgWrite(34, 3);
    cfgWrite(40, 2); cfgWrite(41, 7);
    cyc(1'b1, 1'b0, 16'h0050, 0, 1'b0); // out of order
    cyc(1'b1, 1'b0, 16'h0040, 0, 1'b0); // step 1
    cyc(1'b1, 1'b0, 16'h0040, 0, 1'b0); // ignored
    cyc(1'b1, 1'b1, 16'h0015, 0, 1'b0); // step 2
    cyc(1'b1, 1'b1, 16'h0015, 0, 1'b0); // ignored
    cyc(1'b1, 1'b0, 16'h0050, 0, 1'b0); // fire

    // R7, R8: every action setting, with mixed traffic
    for (int ac = 0; ac < 8; ac++) begin
      cfgWrite(41, ac);
      for (int i = 0; i < 60; i++) begin
        int pick = $urandom_range(0, 4);
        int a = (pick == 0) ? 16'h0010 : (pick == 1) ? 16'h0015 :
                (pick == 2) ? 16'h0040 : (pick == 3) ? 16'h0050 : 16'h0099;
        cyc(1'b1, 1'($urandom_range(0, 1)), a, 0, 1'b0);
      end
    end

    // R6: every length, with length writes rewinding the sequence
    for (int L = 0; L < 4; L++) begin
      cfgWrite(35, 1);
      cfgWrite(40, L);
      for (int i = 0; i < 40; i++) begin
        int pick = $urandom_range(0, 3);
        int a = (pick == 0) ? 16'h0015 : (pick == 1) ? 16'h0040 :
                (pick == 2) ? 16'h0050 : 16'h0300;
        cyc(1'b1, 1'b1, a, 16'h00A5, 1'b0);
      end
    end

    // R9: restart mid-sequence and on the final match
    cfgWrite(40, 2);
    cyc(1'b1, 1'b0, 16'h0040, 0, 1'b0);
    cyc(1'b1, 1'b0, 16'h0015, 0, 1'b0);
    cyc(1'b1, 1'b0, 16'h0050, 0, 1'b1); // final match blocked
    cyc(1'b1, 1'b0, 16'h0050, 0, 1'b0); // no trigger, back at step 0
    cyc(1'b1, 1'b0, 16'h0040, 0, 1'b0);
    cfgWrite(42, 0);                    // restart between cycles
    cyc(1'b1, 1'b0, 16'h0015, 0, 1'b0); // must not advance
    cyc(1'b1, 1'b0, 16'h0040, 0, 1'b0);
    cyc(1'b1, 1'b0, 16'h0015, 0, 1'b0);
    cyc(1'b1, 1'b0, 16'h0050, 0, 1'b0); // fire

    finishRun();
  end

endmodule